// File: doc/BRIEF.md
# Window Watchdog with Parity-Guarded Service Register

This block supervises system software with a window watchdog that counts prescaled ticks. Each watchdog period has two parts. First comes a closed window, in which servicing is forbidden. An open window follows it, in which servicing is expected. Software services the watchdog by writing an 8-bit control byte. Every write that is accepted restarts the period with a fresh closed window. An accepted write also loads the period-select field, so a single write can refresh the watchdog and reconfigure it.

A write is accepted only if the eight written bits have even parity. Bit 7 serves as the checksum bit that software sets to make the parity even. Bit 3 is reserved and always reads back as zero, but the value actually written to it still takes part in the parity check. A write with wrong parity is dropped completely and sets a sticky failure flag, which stays set until software clears it.

The active-low reset output goes low in two cases: service in the closed window, or a whole period with no service. It is held low for a fixed number of ticks, and then the watchdog starts again with a fresh closed window.

Top module: `wdog_window`

## Requirements
- R1: After `rst_n` is released, `wd_rst_n` is 1, `cmd_fail` is 0, `rd_data` is 0x00 and the period is 16 ticks.
- R2: A write is valid only when the XOR of all eight bits of `wr_data` is 0. Bit 7 is the checksum bit that software sets to reach even parity, and reserved bit 3 counts in the parity with its written value.
- R3: A write with odd parity does not refresh the watchdog and does not change `rd_data`. It also sets `cmd_fail` on the next clock edge.
- R4: `cmd_fail` stays set until a cycle with `fail_clr` high and no odd-parity write. When both happen in the same cycle, the flag stays set.
- R5: After a valid write, `rd_data` returns the written byte with bit 3 forced to 0.
- R6: Bits [1:0] of the stored byte select the period: 0 gives 16 ticks, 1 gives 32, 2 gives 64 and 3 gives 128.
- R7: The closed window covers the first C ticks of the period, where C is 60% of the period rounded down (9, 19, 38 and 76 ticks). A valid write after fewer than C ticks drives `wd_rst_n` low. A valid write after C or more ticks restarts the period.
- R8: If P ticks pass with no valid write, where P is the period, `wd_rst_n` goes low on the clock edge of the P-th tick.
- R9: `wd_rst_n` stays low for 8 ticks and rises on the 8th tick. A new period then begins with its closed window.
- R10: A valid write that changes the period is judged against the window of the old period. The new period applies from the restart that follows.
- R11: While `wd_rst_n` is low, valid writes update the stored byte but do not end or extend the low phase. Odd-parity writes still set `cmd_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled time base, one-cycle pulse per tick |
| wr_en | input | 1 | Control-byte write strobe |
| wr_data | input | 8 | Written control byte |
| rd_data | output | 8 | Readback of the control byte (bit 3 reads 0) |
| fail_clr | input | 1 | Clears the sticky failure flag |
| cmd_fail | output | 1 | Sticky flag, set by an odd-parity write |
| wd_rst_n | output | 1 | Active-low watchdog reset |

## Verification
A table of cases services the watchdog after a varying number of ticks for each of the four period settings. Each setting is tried one tick before the closed-window boundary, exactly at the boundary and near the end of the period, which separates the closed window, the open window and the rounding of the boundary. Directed cases cover:
- a lapse with no service, and the exact length of the low phase;
- writes with odd parity, including parity made even or odd only by the reserved bit;
- period changes that would be judged differently under the old and the new window;
- writes made while the reset output is low.

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int BASE_TICKS  = 16,
  parameter int CLOSED_PCT  = 60,
  parameter int HOLD_TICKS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       fail_clr,
  output logic       cmd_fail,
  output logic       wd_rst_n
);

  localparam int CW = $clog2(BASE_TICKS * 8 + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

  logic [3:0]    hi_q;
  logic [2:0]    lo_q;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hold_cnt;
  logic          hold;
  logic [CW-1:0] period_w, closed_w;

  wire parity_ok = ~^wr_data;
  wire wr_ok     = wr_en & parity_ok;
  wire wr_bad    = wr_en & ~parity_ok;
  wire in_closed = cnt < closed_w;
  wire hold_end  = hold & tick & (hold_cnt == HOLD_LAST);

  assign rd_data  = {hi_q, 1'b0, lo_q};
  assign wd_rst_n = ~hold;

  always_comb begin
    period_w = CW'(BASE_TICKS) << lo_q[1:0];
    closed_w = CW'((int'(period_w) * CLOSED_PCT) / 100);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      lo_q     <= '0;
      cmd_fail <= 1'b0;
    end else begin
      if (wr_ok) begin
        hi_q <= wr_data[7:4];
        lo_q <= wr_data[2:0];
      end
      if (wr_bad)        cmd_fail <= 1'b1;
      else if (fail_clr) cmd_fail <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      hold     <= 1'b0;
      hold_cnt <= '0;
    end else if (hold) begin
      if (tick) begin
        if (hold_cnt == HOLD_LAST) begin
          hold     <= 1'b0;
          hold_cnt <= '0;
          cnt      <= '0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
    end else if (wr_ok) begin
      cnt <= '0;
      if (in_closed) begin
        hold     <= 1'b1;
        hold_cnt <= '0;
      end
    end else if (tick) begin
      if (cnt == period_w - 1'b1) begin
        cnt      <= '0;
        hold     <= 1'b1;
        hold_cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_fail_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> cmd_fail);

  assert_cfg_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> rd_data == $past(rd_data));

  assert_fail_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_clr && !wr_bad) |=> !cmd_fail);

  assert_closed_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst_n && wr_ok && in_closed) |=> !wd_rst_n);

  assert_open_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst_n && wr_ok && !in_closed) |=> (wd_rst_n && cnt == '0));

  assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst_n && !wr_ok && tick && cnt == period_w - 1'b1) |=> !wd_rst_n);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_end |=> (wd_rst_n && cnt == '0));

  assert_hold_notrig_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_rst_n && wr_ok && !hold_end) |=> !wd_rst_n);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_n |-> cnt < period_w);

endmodule

// File: tb/wdog_window_bench.sv
module wdog_window_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, fail_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic cmd_fail, wd_rst_n;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  wdog_window u_wdog_window (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .fail_clr(fail_clr), .cmd_fail(cmd_fail), .wd_rst_n(wd_rst_n)
  );

  // {expected wd_rst_n, period select, ticks before service}
  localparam logic [10:0] VEC [0:12] = '{
    {1'b0, 2'd0, 8'd8},   {1'b1, 2'd0, 8'd9},   {1'b1, 2'd0, 8'd15},
    {1'b0, 2'd0, 8'd16},  {1'b0, 2'd1, 8'd18},  {1'b1, 2'd1, 8'd19},
    {1'b1, 2'd1, 8'd31},  {1'b0, 2'd2, 8'd37},  {1'b1, 2'd2, 8'd38},
    {1'b0, 2'd3, 8'd75},  {1'b1, 2'd3, 8'd76},  {1'b1, 2'd3, 8'd127},
    {1'b0, 2'd3, 8'd128}
  };

  function automatic logic [7:0] mk(input logic [1:0] sel, input logic [3:0] spare);
    logic [6:0] low;
    low = {spare[3:1], 1'b0, spare[0], sel};
    return {^low, low};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; @(negedge clk); wr_en = 1'b0; @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    check({7'd0, wd_rst_n}, 8'd1, "R1 wd_rst_n");
    check({7'd0, cmd_fail}, 8'd0, "R1 cmd_fail");
    check(rd_data, 8'h00, "R1 rd_data");
    ticks(15);
    check({7'd0, wd_rst_n}, 8'd1, "R1 16-tick period, tick 15");
    ticks(1);
    check({7'd0, wd_rst_n}, 8'd0, "R8 timeout at tick 16");

    // R6 R7 R8 table of period/window cases
    for (int v = 0; v < 13; v++) begin
      do_reset();
      ticks(10);
      wr(mk(VEC[v][9:8], 4'd0));
      check(rd_data, mk(VEC[v][9:8], 4'd0), "R6 period select stored");
      ticks(int'(VEC[v][7:0]));
      if (VEC[v][7:0] < 8'd128) wr(mk(VEC[v][9:8], 4'd0));
      check({7'd0, wd_rst_n}, {7'd0, VEC[v][10]}, "R7 window table");
    end

    // R9 hold length and fresh closed window
    do_reset();
    ticks(16);
    ticks(7);
    check({7'd0, wd_rst_n}, 8'd0, "R9 still low after 7 hold ticks");
    ticks(1);
    check({7'd0, wd_rst_n}, 8'd1, "R9 released on 8th tick");
    ticks(8);
    wr(mk(2'd0, 4'd0));
    check({7'd0, wd_rst_n}, 8'd0, "R9 fresh closed window after release");

    // R3 odd-parity write ignored
    do_reset();
    ticks(10);
    wr(8'h01);
    check({7'd0, cmd_fail}, 8'd1, "R3 cmd_fail set");
    check(rd_data, 8'h00, "R3 setting unchanged");
    check({7'd0, wd_rst_n}, 8'd1, "R3 no reset from bad write");
    ticks(6);
    check({7'd0, wd_rst_n}, 8'd0, "R3 no refresh, timeout at tick 16");

    // R4 sticky flag and clear
    do_reset();
    wr(8'h02);
    ticks(5);
    check({7'd0, cmd_fail}, 8'd1, "R4 flag sticky");
    fail_clr = 1'b1; @(negedge clk); fail_clr = 1'b0; @(negedge clk);
    check({7'd0, cmd_fail}, 8'd0, "R4 flag cleared");
    fail_clr = 1'b1; wr_en = 1'b1; wr_data = 8'h04; @(negedge clk);
    fail_clr = 1'b0; wr_en = 1'b0; @(negedge clk);
    check({7'd0, cmd_fail}, 8'd1, "R4 set wins over clear");

    // R2 R5 reserved bit counts in parity, reads as 0
    do_reset();
    ticks(10);
    wr(8'h08);
    check({7'd0, cmd_fail}, 8'd1, "R2 reserved bit alone is odd");
    check(rd_data, 8'h00, "R2 odd write not stored");
    wr(8'h88);
    check({7'd0, cmd_fail}, 8'd1, "R2 flag unchanged by valid write");
    check(rd_data, 8'h80, "R5 readback bit 3 is 0");
    check({7'd0, wd_rst_n}, 8'd1, "R2 even write serviced in open window");
    wr(8'hF7 & 8'h77);
    check(rd_data, 8'h77 & 8'hF7, "R5 multi-bit byte stored");

    // R10 judged against old window
    do_reset();
    ticks(10);
    wr(mk(2'd3, 4'd0));
    check({7'd0, wd_rst_n}, 8'd1, "R10 change to 128 accepted in old open window");
    ticks(10);
    wr(mk(2'd0, 4'd0));
    check({7'd0, wd_rst_n}, 8'd0, "R10 change to 16 rejected in old closed window");
    check(rd_data, mk(2'd0, 4'd0), "R10 setting still stored");

    // R11 writes during hold
    wr(mk(2'd1, 4'd5));
    check({7'd0, wd_rst_n}, 8'd0, "R11 valid write does not end hold");
    check(rd_data, mk(2'd1, 4'd5), "R11 setting updated in hold");
    wr(8'h10);
    check({7'd0, cmd_fail}, 8'd1, "R11 bad write in hold sets flag");
    ticks(8);
    check({7'd0, wd_rst_n}, 8'd1, "R11 hold still 8 ticks");
    ticks(31);
    check({7'd0, wd_rst_n}, 8'd1, "R11 new 32-tick period, tick 31");
    ticks(1);
    check({7'd0, wd_rst_n}, 8'd0, "R11 timeout at tick 32");

    finish_run();
  end
endmodule